// File: doc/BRIEF.md
# Chainable 24-Bit Serial Command Receiver

This block is the serial slave front end of a multi-channel converter control chip. A host shifts 24-bit frames into it over three wires: an active-low select, a serial clock and a data line. Each frame holds an 8-bit command followed by a 16-bit data word. When a full frame has arrived, the block gives the register logic a one-cycle strobe together with the decoded command and data. All logic runs on a fast system clock. The three serial pins are synchronized and edge-detected inside the block, so the system clock must run at least four times faster than the serial clock.

An active-low ready output goes low once this device has taken its 24 bits. It can drive the select input of the next device in a chain, which then takes the following 24 bits. A frame that is cut short is dropped without any strobe. A power-control command can switch the ready output off.

The control is a three-state machine. IDLE waits with select high. SHIFT counts sampled bits. DONE holds after the 24th bit and ignores any further clocks. The transitions are: IDLE to SHIFT when select goes low; SHIFT to DONE on the 24th falling clock edge; SHIFT to IDLE (abort) when select rises early; DONE to IDLE when select rises.

Top module: `serial_frame_rx`

## Requirements
- R1: Data is sampled on falling serial clock edges while select is low, most significant bit first. The first 8 bits form `cmd` (first bit is `cmd[7]`) and the next 16 form `data` (last bit is `data[0]`).
- R2: After the 24th falling edge, `frame_valid` is high for exactly one system clock cycle. `cmd` and `data` then hold their values until the next complete frame.
- R3: If select rises before 24 bits have arrived, no strobe is issued and `cmd`/`data` keep their old values. The next select fall starts a fresh frame.
- R4: Bits clocked after the 24th while select stays low are ignored: there is no second strobe and no change to `cmd`/`data`.
- R5: `rdy_n` goes low within a few system cycles of the 24th bit (when ready is enabled) and stays low while select stays low. It returns high after select rises.
- R6: Command 0x03 (power control) loads the ready-enable flag from data bit D0. While the flag is 0, `rdy_n` stays high.
- R7: After reset, `rdy_n` is high, ready is enabled, `frame_valid` is low and `cmd`/`data` are zero.
- R8: The serial clock level and any clock toggles while select is high have no effect. The frame begins at the select fall, whether the clock idles high or low.
- R9: The bit counter saturates at 24 and clears when select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| rdy_n | output | 1 | Active-low ready, usable as the next device's select |
| frame_valid | output | 1 | One-cycle strobe when a full frame has been received |
| cmd | output | 8 | Command byte of the last complete frame |
| data | output | 16 | Data word of the last complete frame |

## Verification
The bench goes after the frame boundaries.

- **Short frame:** a design that kept a partial count across a select pulse would strobe on a later frame with shifted data.
- **Overlong frame:** a counter that wrapped instead of saturating would fire a second strobe and overwrite the word with trailing bits.
- **Clock idle level:** sending frames with the clock idling both high and low, with toggles while deselected, exposes a design that counts clock edges outside select.
- **Ready disable:** turning ready off and back on with command 0x03 catches a ready path that ignores the enable flag or lets `rdy_n` glitch low on the disabling frame.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int FRAME_BITS = 24;
    localparam int CMD_BITS   = 8;
    localparam int DATA_BITS  = FRAME_BITS - CMD_BITS;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [W-1:0] chain [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign prev = chain[STAGES];
endmodule

// File: rtl/sfr_frame_fsm.sv
module sfr_frame_fsm
    import sfr_pkg::*;
#(
    parameter int FB = FRAME_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          sck_fall,
    input  logic          sdi_lvl,
    output logic          last_bit,
    output logic [FB-1:0] frame_nx,
    output logic          done_nx,
    output logic          valid,
    output logic [FB-1:0] frame_q
);
    localparam int CW = $clog2(FB + 1);

    rx_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [FB-1:0] shreg_q, shreg_d;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        shreg_d  = shreg_q;
        last_bit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (!cs_lvl) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_lvl) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (sck_fall) begin
                    shreg_d = {shreg_q[FB-2:0], sdi_lvl};
                    cnt_d   = cnt_q + CW'(1);
                    if (cnt_q == CW'(FB - 1)) begin
                        last_bit = 1'b1;
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                if (cs_lvl) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign frame_nx = shreg_d;
    assign done_nx  = (state_d == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shreg_q <= shreg_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            frame_q <= '0;
        end else begin
            valid <= last_bit;
            if (last_bit) frame_q <= shreg_d;
        end
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(FB)); // R9
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R2
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_SHIFT) |-> !valid); // R3
    AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) == ST_SHIFT) |-> valid); // R2
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> cnt_q == '0); // R9
endmodule

// File: rtl/sfr_ready_ctrl.sv
module sfr_ready_ctrl
    import sfr_pkg::*;
#(
    parameter int          FB      = FRAME_BITS,
    parameter int          CB      = CMD_BITS,
    parameter logic [7:0]  CMD_PWR = 8'h03,
    parameter int          EN_BIT  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          last_bit,
    input  logic [FB-1:0] frame_nx,
    input  logic          done_nx,
    output logic          rdy_n
);
    logic en_q, en_nx;

    always_comb begin
        en_nx = en_q;
        if (last_bit && frame_nx[FB-1 -: CB] == CMD_PWR[CB-1:0])
            en_nx = frame_nx[EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b1;
            rdy_n <= 1'b1;
        end else begin
            en_q  <= en_nx;
            rdy_n <= ~(done_nx & en_nx);
        end
    end

    AST_RDY_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done_nx) |-> rdy_n); // R5
    AST_RDY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_nx) |-> rdy_n); // R6
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import sfr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 sdi,
    output logic                 rdy_n,
    output logic                 frame_valid,
    output logic [CMD_BITS-1:0]  cmd,
    output logic [DATA_BITS-1:0] data
);
    logic [2:0]            pin_lvl, pin_prev;
    logic                  sck_fall, last_bit, done_nx;
    logic [FRAME_BITS-1:0] frame_nx, frame_q;

    sfr_pin_sync #(.W(3), .STAGES(2), .RST_VAL(3'b111)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sck, sdi}),
        .lvl  (pin_lvl),
        .prev (pin_prev)
    );

    // falling serial clock counts only while select is low
    assign sck_fall = pin_prev[1] & ~pin_lvl[1] & ~pin_lvl[2];

    sfr_frame_fsm #(.FB(FRAME_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_lvl  (pin_lvl[2]),
        .sck_fall(sck_fall),
        .sdi_lvl (pin_lvl[0]),
        .last_bit(last_bit),
        .frame_nx(frame_nx),
        .done_nx (done_nx),
        .valid   (frame_valid),
        .frame_q (frame_q)
    );

    sfr_ready_ctrl #(.FB(FRAME_BITS), .CB(CMD_BITS)) u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .last_bit(last_bit),
        .frame_nx(frame_nx),
        .done_nx (done_nx),
        .rdy_n   (rdy_n)
    );

    assign cmd  = frame_q[FRAME_BITS-1 -: CMD_BITS];
    assign data = frame_q[DATA_BITS-1:0];
endmodule

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b1;
    logic        sdi = 1'b0;
    logic        rdy_n, frame_valid;
    logic [7:0]  cmd;
    logic [15:0] data;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int wide = 0;
    logic valid_last = 1'b0;
    bit finished = 1'b0;

    localparam int HP = 4;

    always #10 clk = ~clk;

    serial_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .rdy_n(rdy_n), .frame_valid(frame_valid), .cmd(cmd), .data(data)
    );

    always @(negedge clk) begin
        if (frame_valid && !valid_last) pulses++;
        if (frame_valid && valid_last) wide++;
        valid_last <= frame_valid;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input int n, input logic [31:0] v);
        cs_n = 1'b0;
        cyc(4);
        for (int i = n - 1; i >= 0; i--) begin
            sck = 1'b1; sdi = v[i]; cyc(HP);
            sck = 1'b0; cyc(HP);
        end
        cyc(6);
    endtask

    task automatic release_cs(input logic idle_sck);
        cs_n = 1'b1;
        sck  = idle_sck;
        cyc(6);
    endtask

    task automatic t_reset;
        chk(rdy_n === 1'b1, "R7 rdy_n", rdy_n, 1);
        chk(frame_valid === 1'b0, "R7 valid", frame_valid, 0);
        chk({cmd, data} === 24'h0, "R7 cmd/data", {cmd, data}, 0);
    endtask

    task automatic t_basic;
        int p0 = pulses;
        shift_bits(24, 32'h005AC3A1);
        chk(pulses == p0 + 1, "R2 one strobe", pulses - p0, 1);
        chk(cmd === 8'h5A, "R1 cmd", cmd, 8'h5A);
        chk(data === 16'hC3A1, "R1 data", data, 16'hC3A1);
        chk(rdy_n === 1'b0, "R5 rdy low", rdy_n, 0);
        release_cs(1'b1);
        chk(rdy_n === 1'b1, "R5 rdy high after cs", rdy_n, 1);
        chk(wide == 0, "R2 strobe width", wide, 0);
    endtask

    task automatic t_abort;
        int p0 = pulses;
        shift_bits(13, 32'h00001FFF);
        chk(rdy_n === 1'b1, "R3 rdy stays high", rdy_n, 1);
        release_cs(1'b1);
        chk(pulses == p0, "R3 no strobe", pulses - p0, 0);
        chk({cmd, data} === 24'h5AC3A1, "R3 word kept", {cmd, data}, 24'h5AC3A1);
        shift_bits(24, 32'h00A50F0F);
        release_cs(1'b1);
        chk({cmd, data} === 24'hA50F0F, "R3 fresh frame", {cmd, data}, 24'hA50F0F);
    endtask

    task automatic t_extra;
        int p0 = pulses;
        shift_bits(32, 32'h112233FF);
        chk(pulses == p0 + 1, "R4 single strobe", pulses - p0, 1);
        chk({cmd, data} === 24'h112233, "R4 word", {cmd, data}, 24'h112233);
        chk(rdy_n === 1'b0, "R5 rdy held low", rdy_n, 0);
        release_cs(1'b1);
    endtask

    task automatic t_idle_low;
        int p0 = pulses;
        sck = 1'b0; cyc(4);
        for (int i = 0; i < 5; i++) begin
            sck = 1'b1; cyc(HP); sck = 1'b0; cyc(HP);
        end
        chk(pulses == p0, "R8 no strobe while deselected", pulses - p0, 0);
        shift_bits(24, 32'h007E0F0F);
        release_cs(1'b0);
        chk({cmd, data} === 24'h7E0F0F, "R8 idle-low frame", {cmd, data}, 24'h7E0F0F);
        chk(pulses == p0 + 1, "R9 strobe count", pulses - p0, 1);
        sck = 1'b1; cyc(2);
    endtask

    task automatic t_rdy_dis;
        shift_bits(24, 32'h00030000);
        chk(rdy_n === 1'b1, "R6 disabled on power cmd", rdy_n, 1);
        release_cs(1'b1);
        shift_bits(24, 32'h00441234);
        chk(data === 16'h1234, "R6 frame still taken", data, 16'h1234);
        chk(rdy_n === 1'b1, "R6 rdy kept high", rdy_n, 1);
        release_cs(1'b1);
        shift_bits(24, 32'h00030001);
        chk(rdy_n === 1'b0, "R6 re-enabled", rdy_n, 0);
        release_cs(1'b1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_basic();
        t_abort();
        t_extra();
        t_idle_low();
        t_rdy_dis();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule